// File: doc/BRIEF.md
# Camera Receiver Control and Status Registers

This block is the register file that software uses to set up and watch a serial camera receiver. It sits on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. It drives the static settings that the receiver datapath needs: the block enable, lane polarity swap, per-lane enables, the high-speed settle count, the data-type code, the lane count, the output word alignment, the word-clock source and the frame resolution. It also gathers error and non-image-data event pulses from the datapath into one interrupt line.

Settings that must not change in the middle of a frame are double-buffered. Software writes the settle count, data type, lane count, resolution, alignment and clock select into holding copies. A one-shot update bit in the control word then moves them all to the datapath outputs at once. Event pulses set sticky source bits. Software clears them by writing ones. Each source is gated by a mask, and the four per-lane start-of-transmission error bits share one mask bit. A one-shot soft reset bit clears the sources and returns the double-buffered outputs to their power-up values.

Top module: `camrx_csr`

## Requirements
- R1: After reset these reads return 0: control (0x00), PHY control (0x04), mask (0x10) and source (0x14). Configuration (0x08) reads {RST_DTYPE, 2'b00}, which is 0x78 by default. Resolution (0x2C) reads {RST_WIDTH, RST_HEIGHT}, which is 0x028001E0 by default. The outputs show the same values, and irq_o is 0.
- R2: The register map reads back as follows.
  - Control keeps bit 0 (enable), bit 8 (external word clock), bit 20 (32-bit alignment) and bit 31 (lane swap).
  - PHY control keeps bits 4:0 (lane enables) and bits 31:27 (settle count).
  - Configuration keeps bits 7:0: the data type in 7:2 and lanes-1 in 1:0.
  - The mask keeps only the bits in 0xF000103F.
  - Resolution keeps all 32 bits: width in 31:16, height in 15:0.
  - Offset 0x0C returns phy_stat_i.
  - Any other offset reads 0.
- R3: Control bit 0, control bit 31 and PHY control bits 4:0 drive rx_en_o, lane_swap_o and lane_en_o. They take effect at the same edge that takes the write.
- R4: Writes to the settle count, configuration, resolution, alignment bit or clock-select bit leave the matching outputs unchanged. A control write with bit 16 set copies all six held values to the outputs one clock after the write edge. The copy includes the alignment and clock-select values carried by that same write.
- R5: Control bits 16 (update) and 4 (soft reset) always read back as 0.
- R6: A control write with bit 4 set has this effect one clock after the write edge: the source register is cleared, any event in that cycle is lost, and the double-buffered outputs return to their reset values. The held copies keep their contents. If update and soft reset are requested together, the soft reset wins.
- R7: A high hw_evt_i bit sets the matching source bit when its mask is in 0xF000F03F. The groups are errors 5:0, per-lane start errors 15:12 and non-image data 31:28. All other hw_evt_i bits are ignored and read back as 0.
- R8: A source bit stays set until a write of 1 to that bit at offset 0x14 clears it. Bits written as 0 keep their value.
- R9: If an event and a clearing write hit the same source bit in the same cycle, the bit ends up set.
- R10: irq_o is the OR of (source AND effective mask), registered one clock after the source or mask changes. The effective mask is built as follows:
  - Mask bits 31:28 and 5:0 each gate their own source bit.
  - Mask bit 12 gates all of source bits 15:12.
  - Mask bits 13 to 15 are not stored.
- R11: A read has no side effect. Reading the source register leaves it and irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| hw_evt_i | input | 32 | Event pulses from the datapath, in source-bit positions |
| phy_stat_i | input | 32 | PHY status word, read at 0x0C |
| rx_en_o | output | 1 | Receiver enable |
| lane_swap_o | output | 1 | Data lane polarity swap |
| lane_en_o | output | 5 | Clock lane and data lane enables |
| settle_o | output | 5 | Active high-speed settle count |
| data_type_o | output | 6 | Active data-type code |
| lanes_m1_o | output | 2 | Active lane count minus one |
| align32_o | output | 1 | Active 32-bit alignment (0 selects 24-bit) |
| ext_wclk_o | output | 1 | Active external word-clock select |
| pix_w_o | output | 16 | Active pixel width |
| pix_h_o | output | 16 | Active pixel height |
| irq_o | output | 1 | Combined interrupt |

## Verification
The double buffer is tested in three ways: with held writes and no update, with an update that carries new alignment bits in the same word, and with update and soft reset requested together. Together these show whether the outputs follow the holding copies or the bus. Source bits are driven with all-ones event words, with partial clearing writes, and with a clear and an event on the same bit in the same cycle. These patterns separate sticky behaviour, clearing by writing ones, and event priority. Mask patterns that set only bit 12, or only bit 13, against a source set only in bit 13 show how the shared start-error mask works. A reference model checks the read data and every output on each clock, and directed checks pin the expected numeric values.

// File: rtl/camrx_csr.sv
module camrx_csr #(
  parameter int          ADDR_W     = 8,
  parameter logic [15:0] RST_WIDTH  = 16'd640,
  parameter logic [15:0] RST_HEIGHT = 16'd480,
  parameter logic [5:0]  RST_DTYPE  = 6'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [31:0]       hw_evt_i,
  input  logic [31:0]       phy_stat_i,
  output logic              rx_en_o,
  output logic              lane_swap_o,
  output logic [4:0]        lane_en_o,
  output logic [4:0]        settle_o,
  output logic [5:0]        data_type_o,
  output logic [1:0]        lanes_m1_o,
  output logic              align32_o,
  output logic              ext_wclk_o,
  output logic [15:0]       pix_w_o,
  output logic [15:0]       pix_h_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_PHY   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_PSTAT = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_SRC   = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFS_RES   = ADDR_W'('h2C);
  localparam logic [31:0] SRC_VALID  = 32'hF000_F03F;
  localparam logic [31:0] MASK_VALID = 32'hF000_103F;
  localparam logic [31:0] RES_RST    = {RST_WIDTH, RST_HEIGHT};
  localparam logic [7:0]  CFG_RST    = {RST_DTYPE, 2'b00};

  logic        en_q, swap_q, wclk_h, align_h, upd_q, srst_q;
  logic [4:0]  lane_q, settle_h;
  logic [7:0]  cfg_h;
  logic [31:0] res_h, mask_q, src_q, eff_mask, ctrl_rd;
  logic [4:0]  settle_a;
  logic [7:0]  cfg_a;
  logic [31:0] res_a;
  logic        align_a, wclk_a, irq_q;

  wire wr_ctrl = wr_en_i && addr_i == OFS_CTRL;
  wire wr_phy  = wr_en_i && addr_i == OFS_PHY;
  wire wr_cfg  = wr_en_i && addr_i == OFS_CFG;
  wire wr_mask = wr_en_i && addr_i == OFS_MASK;
  wire wr_src  = wr_en_i && addr_i == OFS_SRC;
  wire wr_res  = wr_en_i && addr_i == OFS_RES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; swap_q <= 1'b0; wclk_h <= 1'b0; align_h <= 1'b0;
      upd_q <= 1'b0; srst_q <= 1'b0;
      lane_q <= '0; settle_h <= '0; cfg_h <= CFG_RST; res_h <= RES_RST;
      mask_q <= '0;
    end else begin
      upd_q  <= wr_ctrl & wr_data_i[16];
      srst_q <= wr_ctrl & wr_data_i[4];
      if (wr_ctrl) begin
        en_q    <= wr_data_i[0];
        wclk_h  <= wr_data_i[8];
        align_h <= wr_data_i[20];
        swap_q  <= wr_data_i[31];
      end
      if (wr_phy) begin
        lane_q   <= wr_data_i[4:0];
        settle_h <= wr_data_i[31:27];
      end
      if (wr_cfg)  cfg_h  <= wr_data_i[7:0];
      if (wr_res)  res_h  <= wr_data_i;
      if (wr_mask) mask_q <= wr_data_i & MASK_VALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_a <= '0; cfg_a <= CFG_RST; res_a <= RES_RST;
      align_a <= 1'b0; wclk_a <= 1'b0;
    end else if (srst_q) begin
      settle_a <= '0; cfg_a <= CFG_RST; res_a <= RES_RST;
      align_a <= 1'b0; wclk_a <= 1'b0;
    end else if (upd_q) begin
      settle_a <= settle_h; cfg_a <= cfg_h; res_a <= res_h;
      align_a <= align_h; wclk_a <= wclk_h;
    end
  end

  assign eff_mask = (mask_q & 32'hF000_003F) | {16'h0, {4{mask_q[12]}}, 12'h0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(src_q & eff_mask);
      if (srst_q) src_q <= '0;
      else src_q <= (src_q & ~(wr_src ? wr_data_i : 32'h0)) | (hw_evt_i & SRC_VALID);
    end
  end

  always_comb begin
    ctrl_rd     = '0;
    ctrl_rd[0]  = en_q;
    ctrl_rd[8]  = wclk_h;
    ctrl_rd[20] = align_h;
    ctrl_rd[31] = swap_q;
  end

  always_comb begin
    case (addr_i)
      OFS_CTRL:  rd_data_o = ctrl_rd;
      OFS_PHY:   rd_data_o = {settle_h, 22'h0, lane_q};
      OFS_CFG:   rd_data_o = {24'h0, cfg_h};
      OFS_PSTAT: rd_data_o = phy_stat_i;
      OFS_MASK:  rd_data_o = mask_q;
      OFS_SRC:   rd_data_o = src_q;
      OFS_RES:   rd_data_o = res_h;
      default:   rd_data_o = '0;
    endcase
  end

  assign rx_en_o     = en_q;
  assign lane_swap_o = swap_q;
  assign lane_en_o   = lane_q;
  assign settle_o    = settle_a;
  assign data_type_o = cfg_a[7:2];
  assign lanes_m1_o  = cfg_a[1:0];
  assign align32_o   = align_a;
  assign ext_wclk_o  = wclk_a;
  assign pix_w_o     = res_a[31:16];
  assign pix_h_o     = res_a[15:0];
  assign irq_o       = irq_q;

  AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(srst_q) && !$past(wr_src)) |-> ((src_q & $past(src_q)) == $past(src_q))); // R8
  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(srst_q)) |-> ((src_q & $past(hw_evt_i & SRC_VALID)) == $past(hw_evt_i & SRC_VALID))); // R9
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(upd_q) && !$past(srst_q)) |->
    $stable({settle_o, data_type_o, lanes_m1_o, align32_o, ext_wclk_o, pix_w_o, pix_h_o})); // R4
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_q) |-> (src_q == 32'h0 && data_type_o == RST_DTYPE && pix_w_o == RST_WIDTH)); // R6
  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(rst_n)) |-> $past(src_q != 32'h0)); // R10
endmodule

// File: tb/camrx_csr_tb.sv
module camrx_csr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 1'b0;
  logic [31:0] wd = '0, evt = '0, pstat = '0;
  logic [31:0] rd;
  logic rx_en, swap, align, wclk, irq;
  logic [4:0] lane_en, settle;
  logic [5:0] dtype;
  logic [1:0] lanes;
  logic [15:0] pw, ph;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  camrx_csr dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .hw_evt_i(evt), .phy_stat_i(pstat), .rx_en_o(rx_en),
    .lane_swap_o(swap), .lane_en_o(lane_en), .settle_o(settle), .data_type_o(dtype),
    .lanes_m1_o(lanes), .align32_o(align), .ext_wclk_o(wclk), .pix_w_o(pw),
    .pix_h_o(ph), .irq_o(irq)
  );

  // behavioural reference state
  bit m_en, m_swap, m_wclk, m_align, m_upd, m_rst, a_align, a_wclk, m_irq;
  bit [4:0] m_lane, m_settle, a_settle;
  bit [7:0] m_cfg, a_cfg;
  bit [31:0] m_res, a_res, m_mask, m_src;

  task automatic model_reset();
    m_en = 0; m_swap = 0; m_wclk = 0; m_align = 0; m_upd = 0; m_rst = 0; m_irq = 0;
    m_lane = 0; m_settle = 0; m_cfg = 8'h78; m_res = 32'h0280_01E0; m_mask = 0; m_src = 0;
    a_align = 0; a_wclk = 0; a_settle = 0; a_cfg = 8'h78; a_res = 32'h0280_01E0;
  endtask

  function automatic bit [31:0] model_read(bit [7:0] a);
    case (a)
      8'h00: return {m_swap, 10'd0, m_align, 11'd0, m_wclk, 7'd0, m_en};
      8'h04: return {m_settle, 22'd0, m_lane};
      8'h08: return {24'd0, m_cfg};
      8'h0C: return pstat;
      8'h10: return m_mask;
      8'h14: return m_src;
      8'h2C: return m_res;
      default: return 0;
    endcase
  endfunction

  task automatic model_clock();
    bit [31:0] em;
    em = m_mask & 32'hF000_003F;
    if (m_mask[12]) em = em | 32'h0000_F000;
    m_irq = (m_src & em) != 0;
    if (m_rst) begin
      m_src = 0; a_settle = 0; a_cfg = 8'h78; a_res = 32'h0280_01E0; a_align = 0; a_wclk = 0;
    end else begin
      if (m_upd) begin
        a_settle = m_settle; a_cfg = m_cfg; a_res = m_res; a_align = m_align; a_wclk = m_wclk;
      end
      if (we && addr == 8'h14) m_src = m_src & ~wd;
      m_src = m_src | (evt & 32'hF000_F03F);
    end
    m_upd = we && addr == 8'h00 && wd[16];
    m_rst = we && addr == 8'h00 && wd[4];
    if (we) begin
      case (addr)
        8'h00: begin m_en = wd[0]; m_wclk = wd[8]; m_align = wd[20]; m_swap = wd[31]; end
        8'h04: begin m_lane = wd[4:0]; m_settle = wd[31:27]; end
        8'h08: m_cfg = wd[7:0];
        8'h10: m_mask = wd & 32'hF000_103F;
        8'h2C: m_res = wd;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk("R3 rx_en", rx_en, m_en);
    chk("R3 swap", swap, m_swap);
    chk("R3 lane_en", lane_en, m_lane);
    chk("R4 settle", settle, a_settle);
    chk("R4 dtype", dtype, a_cfg[7:2]);
    chk("R4 lanes", lanes, a_cfg[1:0]);
    chk("R4 align", align, a_align);
    chk("R4 wclk", wclk, a_wclk);
    chk("R4 width", pw, a_res[31:16]);
    chk("R4 height", ph, a_res[15:0]);
    chk("R10 irq", irq, m_irq);
  endtask

  // one clock: drive at negedge, check read, clock, check outputs
  task automatic step(bit [7:0] a, bit w, bit [31:0] d, bit [31:0] e);
    addr = a; we = w; wd = d; evt = e;
    #1 chk("R2 read", rd, model_read(a));
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare_outputs();
    we = 0; evt = 0;
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d); step(a, 1, d, 0); endtask
  task automatic idle(); step(8'h00, 0, 0, 0); endtask

  function automatic bit [31:0] rdreg(bit [7:0] a);
    addr = a; we = 0;
    return 0;
  endfunction

  task automatic peek(bit [7:0] a, output bit [31:0] v);
    addr = a; we = 0;
    #1 v = rd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] v, v2;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(8'h00, v); chk("R1 ctrl", v, 32'h0);
    peek(8'h08, v); chk("R1 cfg", v, 32'h78);
    peek(8'h2C, v); chk("R1 res", v, 32'h0280_01E0);
    peek(8'h14, v); chk("R1 src", v, 32'h0);
    chk("R1 dtype", dtype, 6'h1E);
    chk("R1 irq", irq, 0);
    compare_outputs();
    // R2 readback masks
    wr(8'h00, 32'h8010_0101);
    peek(8'h00, v); chk("R2 ctrl", v, 32'h8010_0101);
    chk("R3 rx_en", rx_en, 1); chk("R3 swap", swap, 1);
    chk("R4 align held", align, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    peek(8'h04, v); chk("R2 phy", v, 32'hF800_001F);
    chk("R3 lane_en", lane_en, 5'h1F);
    chk("R4 settle held", settle, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    peek(8'h10, v); chk("R2 mask", v, 32'hF000_103F);
    wr(8'h10, 32'h0);
    wr(8'h08, 32'hFFFF_FFFF);
    peek(8'h08, v); chk("R2 cfg", v, 32'hFF);
    wr(8'h2C, 32'h1234_5678);
    peek(8'h2C, v); chk("R2 res", v, 32'h1234_5678);
    pstat = 32'hA5A5_0003;
    peek(8'h0C, v); chk("R2 phy status", v, 32'hA5A5_0003);
    peek(8'h18, v); chk("R2 unmapped", v, 32'h0);
    // R4 shadow update
    wr(8'h08, 32'h0000_00AE);
    wr(8'h2C, 32'h0780_0438);
    wr(8'h04, 32'h5000_0007);
    idle();
    chk("R4 dtype held", dtype, 6'h1E);
    chk("R4 width held", pw, 16'd640);
    wr(8'h00, 32'h0011_0101);
    chk("R4 not yet", dtype, 6'h1E);
    idle();
    chk("R4 dtype", dtype, 6'h2B); chk("R4 lanes", lanes, 2);
    chk("R4 settle", settle, 5'd10); chk("R4 width", pw, 16'd1920);
    chk("R4 height", ph, 16'd1080); chk("R4 align", align, 1); chk("R4 wclk", wclk, 1);
    peek(8'h00, v); chk("R5 ctrl bits read 0", v, 32'h0010_0101);
    // R7 events
    step(8'h00, 0, 0, 32'hFFFF_FFFF);
    peek(8'h14, v); chk("R7 src", v, 32'hF000_F03F);
    // R8 w1c
    wr(8'h14, 32'h0000_F000);
    peek(8'h14, v); chk("R8 clear", v, 32'hF000_003F);
    wr(8'h14, 32'h0);
    peek(8'h14, v); chk("R8 zero write", v, 32'hF000_003F);
    // R9 event wins
    step(8'h14, 1, 32'h0000_0003, 32'h0000_0001);
    peek(8'h14, v); chk("R9 event wins", v, 32'hF000_003D);
    // R6 soft reset, together with update
    wr(8'h00, 32'h0011_0011);
    idle();
    peek(8'h14, v); chk("R6 src cleared", v, 32'h0);
    chk("R6 dtype", dtype, 6'h1E); chk("R6 width", pw, 16'd640);
    chk("R6 align", align, 0); chk("R6 settle", settle, 0);
    peek(8'h08, v); chk("R6 held cfg kept", v, 32'hAE);
    peek(8'h00, v); chk("R5 ctrl", v, 32'h0010_0001);
    // R10 interrupt
    step(8'h00, 0, 0, 32'h0000_2000);
    idle();
    chk("R10 masked off", irq, 0);
    wr(8'h10, 32'h0000_2000);
    peek(8'h10, v); chk("R10 bit13 not stored", v, 32'h0);
    idle(); chk("R10 bit13 no irq", irq, 0);
    wr(8'h10, 32'h0000_1000);
    chk("R10 one clock later", irq, 0);
    idle(); chk("R10 group enable", irq, 1);
    // R11 read without side effect
    peek(8'h14, v); idle(); peek(8'h14, v2);
    chk("R11 read stable", v2, v); chk("R11 irq stable", irq, 1);
    wr(8'h14, 32'hFFFF_FFFF);
    idle(); chk("R10 irq drops", irq, 0);
    step(8'h00, 0, 0, 32'h8000_0000);
    wr(8'h10, 32'h8000_0000);
    idle(); chk("R10 single bit", irq, 1);
    // pattern sweep against model
    for (int i = 0; i < 200; i++) begin
      bit [7:0] offs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h2C};
      step(offs[i % 7], (i % 3) != 0, 32'h9E37_79B9 * (i + 1), (i % 5 == 0) ? 32'h1 << (i % 32) : 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule